// File: doc/BRIEF.md
# Capture/Reload Timer with Baud Tick Generation

This block is a 16-bit up-counter with a 16-bit holding register and an external trigger input. Software configures it through a small byte-wide register bus. Three behaviours share the one counter.

- **Capture:** a falling edge on the trigger pin latches the running count into the holding register.
- **Reload:** the counter is reloaded from the holding register on overflow. A trigger edge can also cause the reload.
- **Baud:** the counter runs at half the clock rate and reloads on every overflow. Each overflow becomes a one-cycle tick toward a serial transmitter, a serial receiver, or both.

Two sticky flags record overflow and trigger activity, and their OR drives an interrupt request. The counter either advances on the internal clock or counts falling edges of an external count pin. Both pins pass through a two-stage synchronizer. Any divide-by-16 of the baud ticks happens downstream of this block.

All interfaces are plain control and status pins. No data stream crosses the block edge, so there is no valid/ready handshake and no back-pressure. A bus write completes in the cycle it is presented. A read is combinational on the address.

Top module: `cap_reload_timer`

## Requirements
- R1: After reset, every register reads 0x00, and irq, tx_tick and rx_tick are low.
- R2: Register map:
  - Address 0 is control. Bit 0 selects capture (1) or reload (0), bit 1 selects external counting, bit 2 runs the counter, bit 3 enables the trigger pin, bit 4 selects transmit baud, bit 5 selects receive baud, bit 6 is the trigger flag and bit 7 is the overflow flag.
  - Addresses 1 and 2 are the count low and high bytes.
  - Addresses 3 and 4 are the holding register low and high bytes.
  - Bits 5:0 of control and all count/holding bytes read back what was written.
- R3: While the run bit is 0, the count does not change except through a bus write or a trigger reload, even if the external count pin toggles.
- R4: With run=1, both baud bits 0 and internal counting, the count rises by one on every clock edge.
- R5: In capture mode outside baud mode, an overflow (0xFFFF plus one) wraps the count to 0x0000 and sets the overflow flag.
- R6: In reload mode outside baud mode, an overflow loads the count from the holding register and sets the overflow flag.
- R7: With capture mode and trigger enable set, outside baud mode, a falling edge on trig_pin copies the count into the holding register and sets the trigger flag.
- R8: With reload mode and trigger enable set, outside baud mode, a falling edge on trig_pin loads the count from the holding register and sets the trigger flag.
- R9: A trig_pin falling edge has no effect on count, holding register or flags when trigger enable is 0, or when either baud bit is 1.
- R10: With either baud bit set and internal counting, the count advances on every second clock edge. It reloads from the holding register on each overflow whatever the capture bit says, and the overflow flag is never set.
- R11: Each baud-mode overflow gives exactly one one-cycle pulse, in the following cycle, on tx_tick if bit 4 is set and on rx_tick if bit 5 is set.
- R12: With external counting and run=1, the count rises by one per falling edge of cnt_pin.
- R13: The flags stay set until software writes 1 to their bit position; writing 0 leaves them. irq is high exactly when either flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| cnt_pin | input | 1 | External count input, counted on falling edges |
| trig_pin | input | 1 | Trigger input, acts on falling edges |
| irq | output | 1 | Interrupt request |
| tx_tick | output | 1 | Transmit baud tick |
| rx_tick | output | 1 | Receive baud tick |

## Verification
The hardest state to reach from the ports is an overflow landing at a known cycle while the counter is running. This matters most in baud mode, where the half-rate phase adds an offset. The stimulus starts and stops the counter with bus writes a known number of cycles apart. That gives the bench an exact count of active edges, and it predicts the final count, the overflow flag and the number of ticks from that count. Trigger tests keep the counter stopped, so capture and reload values are fixed regardless of synchronizer latency. Random mode bits then sweep the capture, reload and ignore paths.

// File: rtl/crt_pkg.sv
package crt_pkg;
  localparam int BYTE_W    = 8;
  localparam int CTRL_ADDR = 0;
  localparam int CNT_BASE  = 1;

  typedef struct packed {
    logic ovf_flag;   // bit 7
    logic trig_flag;  // bit 6
    logic rx_baud;    // bit 5
    logic tx_baud;    // bit 4
    logic trig_en;    // bit 3
    logic run;        // bit 2
    logic ext_cnt;    // bit 1
    logic cap_sel;    // bit 0
  } ctrl_t;
endpackage

// File: rtl/crt_edge_sync.sv
module crt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], pin};
      prev  <= chain[STAGES-1];
    end
  end

  assign fall = prev & ~chain[STAGES-1];

  // R12
  single_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/crt_step_gen.sv
module crt_step_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic baud,
  input  logic ext_cnt,
  input  logic ext_fall,
  output logic step
);
  logic phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             phase <= 1'b0;
    else if (run && baud)   phase <= ~phase;
    else                    phase <= 1'b0;
  end

  always_comb begin
    if (!run)         step = 1'b0;
    else if (ext_cnt) step = ext_fall;
    else if (baud)    step = phase;
    else              step = 1'b1;
  end

  // R10
  half_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && baud && !ext_cnt && $past(run && baud && !ext_cnt)) |=> !step);
endmodule

// File: rtl/crt_counter.sv
module crt_counter #(
  parameter int W         = 16,
  parameter int AW        = 3,
  parameter int CNT_BASE  = 1,
  parameter int HOLD_BASE = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          baud,
  input  logic          cap_sel,
  input  logic          trig_hit,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [W-1:0]  count,
  output logic [W-1:0]  hold,
  output logic          ovf_evt
);
  localparam int BYTES = W / 8;

  logic [W-1:0] cnt_hw, hold_hw, cnt_nx, hold_nx;
  logic         cnt_wr, hold_wr;

  assign ovf_evt = step && (&count);

  always_comb begin
    cnt_hw  = count;
    hold_hw = hold;
    if (step) begin
      if (ovf_evt) cnt_hw = (baud || !cap_sel) ? hold : '0;
      else         cnt_hw = count + 1'b1;
    end
    if (trig_hit) begin
      if (cap_sel) hold_hw = count;
      else         cnt_hw  = hold;
    end
  end

  logic [BYTES-1:0] cnt_lane_wr, hold_lane_wr;

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    assign cnt_lane_wr[g]  = wr && (addr == AW'(CNT_BASE + g));
    assign hold_lane_wr[g] = wr && (addr == AW'(HOLD_BASE + g));
    assign cnt_nx[g*8 +: 8]  = cnt_lane_wr[g]  ? wdata : cnt_hw[g*8 +: 8];
    assign hold_nx[g*8 +: 8] = hold_lane_wr[g] ? wdata : hold_hw[g*8 +: 8];
  end

  assign cnt_wr  = |cnt_lane_wr;
  assign hold_wr = |hold_lane_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      hold  <= '0;
    end else begin
      count <= cnt_nx;
      hold  <= hold_nx;
    end
  end

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !trig_hit && !cnt_wr) |=> $stable(count));

  // R10
  baud_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && baud && !trig_hit && !cnt_wr && !hold_wr) |=> (count == $past(hold)));
endmodule

// File: rtl/cap_reload_timer.sv
module cap_reload_timer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       cnt_pin,
  input  logic       trig_pin,
  output logic       irq,
  output logic       tx_tick,
  output logic       rx_tick
);
  import crt_pkg::*;

  localparam int W         = 16;
  localparam int AW        = 3;
  localparam int SYNC      = 2;
  localparam int BYTES     = W / BYTE_W;
  localparam int HOLD_BASE = CNT_BASE + BYTES;

  ctrl_t        ctl;
  logic         ctl_wr, baud, step, ovf_evt, trig_hit;
  logic         cnt_fall, trig_fall;
  logic [W-1:0] count, hold;

  assign ctl_wr   = bus_wr && (bus_addr == AW'(CTRL_ADDR));
  assign baud     = ctl.tx_baud | ctl.rx_baud;
  assign trig_hit = trig_fall && ctl.trig_en && !baud;

  crt_edge_sync #(.STAGES(SYNC)) u_cnt_sync (
    .clk(clk), .rst_n(rst_n), .pin(cnt_pin), .fall(cnt_fall));

  crt_edge_sync #(.STAGES(SYNC)) u_trig_sync (
    .clk(clk), .rst_n(rst_n), .pin(trig_pin), .fall(trig_fall));

  crt_step_gen u_step (
    .clk(clk), .rst_n(rst_n), .run(ctl.run), .baud(baud),
    .ext_cnt(ctl.ext_cnt), .ext_fall(cnt_fall), .step(step));

  crt_counter #(.W(W), .AW(AW), .CNT_BASE(CNT_BASE), .HOLD_BASE(HOLD_BASE)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .baud(baud), .cap_sel(ctl.cap_sel),
    .trig_hit(trig_hit), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .count(count), .hold(hold), .ovf_evt(ovf_evt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl     <= '0;
      tx_tick <= 1'b0;
      rx_tick <= 1'b0;
    end else begin
      if (ctl_wr) begin
        ctl.cap_sel <= bus_wdata[0];
        ctl.ext_cnt <= bus_wdata[1];
        ctl.run     <= bus_wdata[2];
        ctl.trig_en <= bus_wdata[3];
        ctl.tx_baud <= bus_wdata[4];
        ctl.rx_baud <= bus_wdata[5];
      end
      ctl.trig_flag <= (ctl.trig_flag & ~(ctl_wr & bus_wdata[6])) | trig_hit;
      ctl.ovf_flag  <= (ctl.ovf_flag  & ~(ctl_wr & bus_wdata[7])) | (ovf_evt & ~baud);
      tx_tick <= ovf_evt & ctl.tx_baud;
      rx_tick <= ovf_evt & ctl.rx_baud;
    end
  end

  assign irq = ctl.ovf_flag | ctl.trig_flag;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(CTRL_ADDR)) bus_rdata = ctl;
    for (int i = 0; i < BYTES; i++) begin
      if (bus_addr == AW'(CNT_BASE + i))  bus_rdata = count[i*8 +: 8];
      if (bus_addr == AW'(HOLD_BASE + i)) bus_rdata = hold[i*8 +: 8];
    end
  end

  // R10
  no_baud_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl.ovf_flag) |-> $past(ovf_evt && !baud));

  // R7
  trig_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl.trig_flag) |-> $past(trig_fall && ctl.trig_en));

  // R11
  tx_tick_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_tick |-> $past(ctl.tx_baud && ovf_evt));

  // R11
  rx_tick_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_tick |=> !rx_tick);
endmodule

// File: tb/cap_reload_timer_test.sv
`timescale 1ns/1ps
module cap_reload_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       cnt_pin = 1'b1;
  logic       trig_pin = 1'b1;
  logic       irq, tx_tick, rx_tick;

  int total = 0;
  int bad = 0;
  int tx_seen = 0;
  int rx_seen = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  cap_reload_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_pin(cnt_pin),
    .trig_pin(trig_pin), .irq(irq), .tx_tick(tx_tick), .rx_tick(rx_tick));

  always @(negedge clk) begin
    cycles++;
    if (tx_tick) tx_seen++;
    if (rx_tick) rx_seen++;
    if (cycles > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // all tasks start and end at a falling clock edge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
  endtask

  task automatic wr16(input logic [2:0] base, input logic [15:0] v);
    wr(base, v[7:0]);
    wr(base + 3'd1, v[15:8]);
  endtask

  task automatic rd16(input logic [2:0] base, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(base, lo);
    rd(base + 3'd1, hi);
    v = {hi, lo};
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic trig_pulse();
    trig_pin = 1'b0; idle(6);
    trig_pin = 1'b1; idle(4);
  endtask

  // run for k cycles between start write and stop write: k+1 active edges
  task automatic run_window(input logic [7:0] start_ctl, input logic [7:0] stop_ctl, input int k);
    wr(3'd0, start_ctl);
    idle(k);
    wr(3'd0, stop_ctl);
    idle(3);
  endtask

  // returns {overflowed, final count} for n steps
  function automatic logic [16:0] run_model(input logic [15:0] start, input logic [15:0] hold,
                                            input logic reload_on_ovf, input int n);
    logic [15:0] c = start;
    logic        o = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (c == 16'hFFFF) begin
        o = 1'b1;
        c = reload_on_ovf ? hold : 16'h0000;
      end else c = c + 16'd1;
    end
    return {o, c};
  endfunction

  initial begin
    logic [7:0]  r8;
    logic [15:0] r16;
    logic [16:0] m;
    void'($urandom(32'd4242));

    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), r8);
      check("R1 reg", r8, 8'h00);
    end
    check("R1 irq", irq, 1'b0);
    check("R1 ticks", {tx_tick, rx_tick}, 2'b00);

    // R2 map readback
    wr16(3'd1, 16'hA55A);
    wr16(3'd3, 16'h1234);
    rd16(3'd1, r16); check("R2 count", r16, 16'hA55A);
    rd16(3'd3, r16); check("R2 hold", r16, 16'h1234);
    wr(3'd0, 8'h2A);
    rd(3'd0, r8); check("R2 ctrl", r8, 8'h2A);
    wr(3'd0, 8'h00);

    // R3 stopped, including external pin activity
    idle(10);
    for (int i = 0; i < 3; i++) begin cnt_pin = 1'b0; idle(4); cnt_pin = 1'b1; idle(4); end
    rd16(3'd1, r16); check("R3 stopped", r16, 16'hA55A);

    // R4 one per clock
    wr16(3'd1, 16'h0100);
    run_window(8'h04, 8'h00, 9);
    rd16(3'd1, r16); check("R4 count", r16, 16'h010A);

    // R5 overflow in capture mode wraps to zero
    wr16(3'd1, 16'hFFF0);
    run_window(8'h05, 8'h01, 20);
    rd16(3'd1, r16); check("R5 count", r16, 16'h0005);
    rd(3'd0, r8); check("R5 flag", r8, 8'h81);
    check("R13 irq set", irq, 1'b1);
    wr(3'd0, 8'h01);
    rd(3'd0, r8); check("R13 write0 keeps", r8, 8'h81);
    wr(3'd0, 8'h80);
    rd(3'd0, r8); check("R13 w1c", r8, 8'h00);
    check("R13 irq clr", irq, 1'b0);

    // R6 overflow in reload mode
    wr16(3'd3, 16'h4000);
    wr16(3'd1, 16'hFFF0);
    run_window(8'h04, 8'h00, 20);
    rd16(3'd1, r16); check("R6 count", r16, 16'h4005);
    rd(3'd0, r8); check("R6 flag", r8, 8'h80);
    wr(3'd0, 8'h80);

    // R7 capture
    wr16(3'd1, 16'h3C3C);
    wr(3'd0, 8'h09);
    trig_pulse();
    rd16(3'd3, r16); check("R7 hold", r16, 16'h3C3C);
    rd(3'd0, r8); check("R7 flag", r8, 8'h49);
    check("R7 irq", irq, 1'b1);
    wr(3'd0, 8'h40);

    // R8 trigger reload
    wr16(3'd3, 16'h7777);
    wr16(3'd1, 16'h1111);
    wr(3'd0, 8'h08);
    trig_pulse();
    rd16(3'd1, r16); check("R8 count", r16, 16'h7777);
    rd(3'd0, r8); check("R8 flag", r8, 8'h48);
    wr(3'd0, 8'h40);

    // R9 ignored: enable off, then baud on
    wr16(3'd1, 16'h2222);
    wr(3'd0, 8'h01);
    trig_pulse();
    rd16(3'd3, r16); check("R9 no enable hold", r16, 16'h7777);
    rd(3'd0, r8); check("R9 no enable flag", r8, 8'h01);
    wr(3'd0, 8'h18);
    trig_pulse();
    rd16(3'd1, r16); check("R9 baud count", r16, 16'h2222);
    rd(3'd0, r8); check("R9 baud flag", r8, 8'h18);

    // R10 / R11 baud, both ticks; 40 edges -> 20 steps
    wr16(3'd3, 16'hFFF8);
    wr16(3'd1, 16'hFFF8);
    tx_seen = 0; rx_seen = 0;
    run_window(8'h35, 8'h31, 39);
    rd16(3'd1, r16); check("R10 count", r16, 16'hFFFC);
    rd(3'd0, r8); check("R10 no flag", r8, 8'h31);
    check("R11 tx ticks", tx_seen, 2);
    check("R11 rx ticks", rx_seen, 2);

    // R11 transmit only
    wr16(3'd1, 16'hFFF8);
    tx_seen = 0; rx_seen = 0;
    run_window(8'h14, 8'h10, 39);
    check("R11 tx only", tx_seen, 2);
    check("R11 rx quiet", rx_seen, 0);
    wr(3'd0, 8'h00);

    // R12 external edges
    wr16(3'd1, 16'h0000);
    wr(3'd0, 8'h06);
    for (int i = 0; i < 7; i++) begin cnt_pin = 1'b0; idle(4); cnt_pin = 1'b1; idle(4); end
    idle(4);
    wr(3'd0, 8'h02);
    rd16(3'd1, r16); check("R12 ext count", r16, 16'h0007);
    wr(3'd0, 8'h00);

    // random triggers (R7, R8, R9)
    for (int it = 0; it < 30; it++) begin
      logic [15:0] c0, h0, ec, eh;
      logic cap, en, bd;
      logic [7:0] ctl, ef;
      c0 = 16'($urandom); h0 = 16'($urandom);
      cap = 1'($urandom); en = 1'($urandom); bd = 1'($urandom);
      ctl = {2'b00, 1'b0, bd, en, 1'b0, 1'b0, cap};
      wr(3'd0, 8'hC0);
      wr16(3'd1, c0); wr16(3'd3, h0);
      wr(3'd0, ctl);
      trig_pulse();
      ec = c0; eh = h0; ef = ctl;
      if (en && !bd) begin
        if (cap) eh = c0; else ec = h0;
        ef = ctl | 8'h40;
      end
      rd16(3'd1, r16); check("R8/R9 rnd count", r16, ec);
      rd16(3'd3, r16); check("R7/R9 rnd hold", r16, eh);
      rd(3'd0, r8);    check("R7/R8 rnd ctrl", r8, ef);
    end
    wr(3'd0, 8'hC0);

    // random runs near the top (R4, R5, R6)
    for (int it = 0; it < 20; it++) begin
      logic [15:0] c0, h0;
      logic cap;
      int k;
      c0 = 16'hFFC0 | 16'($urandom_range(0, 63));
      h0 = 16'($urandom);
      cap = 1'($urandom);
      k = $urandom_range(0, 80);
      wr16(3'd1, c0); wr16(3'd3, h0);
      run_window({7'b0000010, cap}, {7'b0000000, cap}, k);
      m = run_model(c0, h0, !cap, k + 1);
      rd16(3'd1, r16); check("R4/R5/R6 rnd count", r16, m[15:0]);
      rd(3'd0, r8);    check("R5/R6 rnd flag", r8, {m[16], 6'b0, cap});
      wr(3'd0, 8'h80);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule